// File: doc/BRIEF.md
# SPI Transmit Framing and Receive Buffer with Status

This block sits between a bus-side data register and an SPI shift engine. Bus writes to the data register are collected in a staging area. They are released to the transmit buffer as one group only after a programmed number of frames has arrived. The shift engine takes words from the transmit buffer one at a time and hands each received word back to a single-word receive buffer.

The block keeps these status flags:
- transmit-empty
- receive-full
- overrun
- underrun
- parity error
- mode fault
- idle

It drives four interrupt lines, each gated by its own enable. A read-target select chooses whether data-register reads return the receive buffer or the head of the transmit buffer.

Bus decoding and the serial shifter are outside the block. Plain read and write strobes and an engine request/valid interface are used instead.

Top module: `spi_frame_buf`

## Requirements
- R1: After reset the following hold: `tx_empty_o`=1, `rx_full_o`=0, every error flag is 0, and `idle_o`=1 while `eng_busy_i`=0.
- R2: The frame threshold is `frame_lvl_i`+1 words (1 to 4).
  - Staged words move to the transmit buffer together, on the clock after the staged count reaches the threshold while the transmit buffer is empty.
  - Until then `tx_empty_o` stays 1.
- R3: `eng_tx_data_o` presents buffered words in write order. Each `eng_req_i` cycle consumes the head word. `tx_empty_o` becomes 1 on the clock that takes the last word.
- R4: `eng_req_i` while the transmit buffer is empty sets the underrun flag `udr_o`.
- R5: `eng_rx_valid_i` with the receive buffer free stores `eng_rx_data_i` and sets `rx_full_o`. A data-register read with `rd_sel_tx_i`=0 clears `rx_full_o`.
- R6: A word arriving while `rx_full_o`=1 and no receive read is in progress is discarded. The buffer keeps its old word and `ovr_o` sets.
- R7: `dr_rdata_o` returns the receive buffer when `rd_sel_tx_i`=0 and the transmit-buffer head when `rd_sel_tx_i`=1.
- R8: Overrun, underrun, parity-error and mode-fault flags are sticky. A `clr_i` pulse clears only the flags whose bits are set in `clr_mask_i`. The bit positions are: bit0 overrun, bit1 underrun, bit2 parity error, bit3 mode fault.
- R9: `irq_err_o` = `ie_err_i` AND (`ovr_o` OR `udr_o` OR `perr_o`). Mode fault does not drive it.
- R10: The interrupt outputs follow their flags under their enables:
  - `irq_tx_o` = `ie_tx_i` AND `tx_empty_o`
  - `irq_rx_o` = `ie_rx_i` AND `rx_full_o`
  - `irq_idle_o` = `ie_idle_i` AND `idle_o`
- R11: `idle_o` is 1 only when `eng_busy_i`=0, the transmit buffer is empty and no words are staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dr_wr_i | input | 1 | Data-register write strobe |
| dr_wdata_i | input | DATA_W | Data-register write data |
| dr_rd_i | input | 1 | Data-register read strobe |
| dr_rdata_o | output | DATA_W | Data-register read data |
| rd_sel_tx_i | input | 1 | Read target: 0 receive buffer, 1 transmit head |
| frame_lvl_i | input | LVL_W | Frame threshold minus one |
| eng_req_i | input | 1 | Engine takes a word for the next transfer |
| eng_tx_data_o | output | DATA_W | Word offered to the engine |
| eng_rx_valid_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | DATA_W | Received word |
| eng_busy_i | input | 1 | Engine is shifting |
| parity_err_i | input | 1 | Parity error pulse from the engine |
| mode_fault_i | input | 1 | Mode fault pulse |
| clr_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 4 | Flags to clear |
| ie_tx_i | input | 1 | Transmit-empty interrupt enable |
| ie_rx_i | input | 1 | Receive-full interrupt enable |
| ie_idle_i | input | 1 | Idle interrupt enable |
| ie_err_i | input | 1 | Error interrupt enable |
| tx_empty_o | output | 1 | Transmit buffer empty |
| rx_full_o | output | 1 | Receive buffer holds an unread word |
| ovr_o | output | 1 | Overrun flag |
| udr_o | output | 1 | Underrun flag |
| perr_o | output | 1 | Parity error flag |
| modf_o | output | 1 | Mode fault flag |
| idle_o | output | 1 | Idle status |
| irq_tx_o | output | 1 | Transmit-empty interrupt |
| irq_rx_o | output | 1 | Receive-full interrupt |
| irq_idle_o | output | 1 | Idle interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
A wrong staging count shows one clock after the threshold write: `tx_empty_o` falls too early or too late, or the wrong first word appears at `eng_tx_data_o` and on a transmit-target read. A wrong read pointer in the transmit buffer shows on the very next engine request as a word out of write order. Wrong receive or flag state shows immediately after the offending edge:
- a discarded word overwriting the buffer
- a flag that clears without its mask bit
- an error interrupt that responds to mode fault

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
  localparam int unsigned FLAG_OVR  = 0;
  localparam int unsigned FLAG_UDR  = 1;
  localparam int unsigned FLAG_PERR = 2;
  localparam int unsigned FLAG_MODF = 3;
  localparam int unsigned FLAG_N    = 4;
endpackage

// File: rtl/spi_fb_stage.sv
module spi_fb_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAMES = 4,
  localparam int unsigned LVL_W = $clog2(FRAMES),
  localparam int unsigned CNT_W = $clog2(FRAMES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [LVL_W-1:0]               lvl_i,
  input  logic                           tx_empty_i,
  output logic                           xfer_o,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [FRAMES-1:0][DATA_W-1:0]  words_o
);
  logic [CNT_W-1:0] thr;

  assign thr    = CNT_W'(lvl_i) + CNT_W'(1);
  assign xfer_o = tx_empty_i && (cnt_o >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      words_o <= '0;
    end else if (xfer_o) begin
      // a write in the transfer cycle opens the next group
      cnt_o <= wr_i ? CNT_W'(1) : '0;
      if (wr_i) words_o[0] <= wdata_i;
    end else if (wr_i && cnt_o < CNT_W'(FRAMES)) begin
      words_o[cnt_o[LVL_W-1:0]] <= wdata_i;
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  AST_STAGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(FRAMES)); // R2
endmodule

// File: rtl/spi_fb_txq.sv
module spi_fb_txq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAMES = 4,
  localparam int unsigned LVL_W = $clog2(FRAMES),
  localparam int unsigned CNT_W = $clog2(FRAMES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [CNT_W-1:0]               load_cnt_i,
  input  logic [FRAMES-1:0][DATA_W-1:0]  load_words_i,
  input  logic                           pop_i,
  output logic [DATA_W-1:0]              head_o,
  output logic                           empty_o,
  output logic                           underrun_o
);
  logic [FRAMES-1:0][DATA_W-1:0] mem;
  logic [CNT_W-1:0]              cnt;
  logic [LVL_W-1:0]              rp;

  assign empty_o    = (cnt == '0);
  assign head_o     = mem[rp];
  assign underrun_o = pop_i && empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem <= '0;
      cnt <= '0;
      rp  <= '0;
    end else if (load_i) begin
      mem <= load_words_i;
      cnt <= load_cnt_i;
      rp  <= '0;
    end else if (pop_i && !empty_o) begin
      cnt <= cnt - CNT_W'(1);
      rp  <= rp + LVL_W'(1);
    end
  end

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o); // R2
  AST_TXQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(FRAMES)); // R3
  AST_POP_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !load_i) |=> (rp == $past(rp) + LVL_W'(1))); // R3
endmodule

// File: rtl/spi_fb_rx.sv
module spi_fb_rx #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              overrun_o
);
  logic accept;

  assign accept    = push_i && (!full_o || rd_i);
  assign overrun_o = push_i && full_o && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (accept) begin
      data_o <= pdata_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  AST_RX_FULL_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> full_o); // R5
  AST_RX_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !rd_i) |=> $stable(data_o)); // R6
endmodule

// File: rtl/spi_frame_buf.sv
module spi_frame_buf
  import spi_fb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAMES = 4,
  localparam int unsigned LVL_W = $clog2(FRAMES),
  localparam int unsigned CNT_W = $clog2(FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dr_wr_i,
  input  logic [DATA_W-1:0] dr_wdata_i,
  input  logic              dr_rd_i,
  output logic [DATA_W-1:0] dr_rdata_o,
  input  logic              rd_sel_tx_i,
  input  logic [LVL_W-1:0]  frame_lvl_i,
  input  logic              eng_req_i,
  output logic [DATA_W-1:0] eng_tx_data_o,
  input  logic              eng_rx_valid_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  input  logic              eng_busy_i,
  input  logic              parity_err_i,
  input  logic              mode_fault_i,
  input  logic              clr_i,
  input  logic [3:0]        clr_mask_i,
  input  logic              ie_tx_i,
  input  logic              ie_rx_i,
  input  logic              ie_idle_i,
  input  logic              ie_err_i,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              udr_o,
  output logic              perr_o,
  output logic              modf_o,
  output logic              idle_o,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_idle_o,
  output logic              irq_err_o
);
  logic                          xfer;
  logic [CNT_W-1:0]              stage_cnt;
  logic [FRAMES-1:0][DATA_W-1:0] stage_words;
  logic                          udr_evt;
  logic                          ovr_evt;
  logic [DATA_W-1:0]             rx_data;
  logic                          rx_rd;
  logic [FLAG_N-1:0]             flags;
  logic [FLAG_N-1:0]             set_vec;

  assign rx_rd = dr_rd_i && !rd_sel_tx_i;

  spi_fb_stage #(.DATA_W(DATA_W), .FRAMES(FRAMES)) u_stage (
    .clk_i, .rst_ni,
    .wr_i(dr_wr_i), .wdata_i(dr_wdata_i), .lvl_i(frame_lvl_i),
    .tx_empty_i(tx_empty_o), .xfer_o(xfer), .cnt_o(stage_cnt),
    .words_o(stage_words)
  );

  spi_fb_txq #(.DATA_W(DATA_W), .FRAMES(FRAMES)) u_txq (
    .clk_i, .rst_ni,
    .load_i(xfer), .load_cnt_i(stage_cnt), .load_words_i(stage_words),
    .pop_i(eng_req_i), .head_o(eng_tx_data_o), .empty_o(tx_empty_o),
    .underrun_o(udr_evt)
  );

  spi_fb_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .push_i(eng_rx_valid_i), .pdata_i(eng_rx_data_i), .rd_i(rx_rd),
    .data_o(rx_data), .full_o(rx_full_o), .overrun_o(ovr_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_OVR]  = ovr_evt;
    set_vec[FLAG_UDR]  = udr_evt;
    set_vec[FLAG_PERR] = parity_err_i;
    set_vec[FLAG_MODF] = mode_fault_i;
  end

  // sticky flags: a new event wins over a clear in the same cycle
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flags[g] <= 1'b0;
      else if (set_vec[g])                flags[g] <= 1'b1;
      else if (clr_i && clr_mask_i[g])    flags[g] <= 1'b0;
    end
  end

  assign ovr_o  = flags[FLAG_OVR];
  assign udr_o  = flags[FLAG_UDR];
  assign perr_o = flags[FLAG_PERR];
  assign modf_o = flags[FLAG_MODF];

  assign idle_o     = !eng_busy_i && tx_empty_o && (stage_cnt == '0);
  assign dr_rdata_o = rd_sel_tx_i ? eng_tx_data_o : rx_data;

  assign irq_tx_o   = ie_tx_i && tx_empty_o;
  assign irq_rx_o   = ie_rx_i && rx_full_o;
  assign irq_idle_o = ie_idle_i && idle_o;
  assign irq_err_o  = ie_err_i && (ovr_o || udr_o || perr_o);

  AST_UDR_ON_EMPTY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_i && tx_empty_o) |=> udr_o); // R4
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(clr_i && clr_mask_i[FLAG_OVR])) |=> ovr_o); // R8
  AST_MODF_NO_ERR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_o && !udr_o && !perr_o) |-> !irq_err_o); // R9
  AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (tx_empty_o && !eng_busy_i)); // R11
endmodule

// File: tb/spi_frame_buf_tb_top.sv
module spi_frame_buf_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dr_wr = 0, dr_rd = 0, rd_sel_tx = 0, eng_req = 0, eng_rx_valid = 0;
  logic eng_busy = 0, parity_err = 0, mode_fault = 0, clr = 0;
  logic ie_tx = 0, ie_rx = 0, ie_idle = 0, ie_err = 0;
  logic [DW-1:0] dr_wdata = '0, eng_rx_data = '0;
  logic [1:0] frame_lvl = '0;
  logic [3:0] clr_mask = '0;
  logic [DW-1:0] dr_rdata, eng_tx_data;
  logic tx_empty, rx_full, ovr, udr, perr, modf, idle;
  logic irq_tx, irq_rx, irq_idle, irq_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .dr_wr_i(dr_wr), .dr_wdata_i(dr_wdata), .dr_rd_i(dr_rd), .dr_rdata_o(dr_rdata),
    .rd_sel_tx_i(rd_sel_tx), .frame_lvl_i(frame_lvl),
    .eng_req_i(eng_req), .eng_tx_data_o(eng_tx_data),
    .eng_rx_valid_i(eng_rx_valid), .eng_rx_data_i(eng_rx_data),
    .eng_busy_i(eng_busy), .parity_err_i(parity_err), .mode_fault_i(mode_fault),
    .clr_i(clr), .clr_mask_i(clr_mask),
    .ie_tx_i(ie_tx), .ie_rx_i(ie_rx), .ie_idle_i(ie_idle), .ie_err_i(ie_err),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .ovr_o(ovr), .udr_o(udr),
    .perr_o(perr), .modf_o(modf), .idle_o(idle),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_idle_o(irq_idle), .irq_err_o(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 flags", {ovr, udr, perr, modf}, 0);
    chk("R1 idle", idle, 1);
    // R10 gating with enables off and on
    chk("R10 irq_tx off", irq_tx, 0);
    ie_tx = 1; ie_idle = 1; #1;
    chk("R10 irq_tx on", irq_tx, 1);
    chk("R10 irq_idle on", irq_idle, 1);

    for (int lvl = 0; lvl < 4; lvl++) begin
      frame_lvl = 2'(lvl);
      for (int i = 0; i <= lvl; i++) begin
        dr_wr = 1; dr_wdata = DW'(16'h1000 + lvl * 16 + i);
        step();
        dr_wr = 0;
        chk("R2 held until threshold", tx_empty, 1);
        chk("R11 not idle while staged", idle, 0);
      end
      step();
      chk("R2 loaded after threshold", tx_empty, 0);
      chk("R10 irq_tx follows", irq_tx, 0);
      rd_sel_tx = 1; #1;
      chk("R7 tx target read", dr_rdata, 32'(16'h1000 + lvl * 16));
      rd_sel_tx = 0;
      for (int i = 0; i <= lvl; i++) begin
        chk("R3 order", eng_tx_data, 32'(16'h1000 + lvl * 16 + i));
        eng_req = 1;
        step();
        eng_req = 0;
        chk("R3 empty after last", tx_empty, (i == lvl) ? 1 : 0);
      end
      chk("R4 no underrun yet", udr, 0);
      eng_req = 1;
      step();
      eng_req = 0;
      chk("R4 underrun set", udr, 1);
      ie_err = 1; #1;
      chk("R9 err irq on underrun", irq_err, 1);
      ie_err = 0;
      clr = 1; clr_mask = 4'b0010;
      step();
      clr = 0;
      chk("R8 underrun cleared", udr, 0);
    end

    // R5 / R6 / R7 receive path
    ie_rx = 1;
    eng_rx_valid = 1; eng_rx_data = 16'hA5A5;
    step();
    eng_rx_valid = 0;
    chk("R5 rx_full set", rx_full, 1);
    chk("R7 rx target read", dr_rdata, 16'hA5A5);
    chk("R10 irq_rx", irq_rx, 1);
    eng_rx_valid = 1; eng_rx_data = 16'h5A5A;
    step();
    eng_rx_valid = 0;
    chk("R6 overrun set", ovr, 1);
    chk("R6 old word kept", dr_rdata, 16'hA5A5);
    dr_rd = 1;
    step();
    dr_rd = 0;
    chk("R5 read clears rx_full", rx_full, 0);
    chk("R10 irq_rx off", irq_rx, 0);
    // R8 mask selectivity
    clr = 1; clr_mask = 4'b1110;
    step();
    clr = 0;
    chk("R8 other mask keeps overrun", ovr, 1);
    clr = 1; clr_mask = 4'b0001;
    step();
    clr = 0;
    chk("R8 overrun cleared", ovr, 0);

    // R9 parity and mode fault
    parity_err = 1;
    step();
    parity_err = 0;
    chk("R8 parity sticky", perr, 1);
    ie_err = 1; #1;
    chk("R9 err irq on parity", irq_err, 1);
    ie_err = 0; #1;
    chk("R9 err irq gated", irq_err, 0);
    clr = 1; clr_mask = 4'b0100;
    step();
    clr = 0;
    mode_fault = 1;
    step();
    mode_fault = 0;
    ie_err = 1; #1;
    chk("R8 mode fault set", modf, 1);
    chk("R9 mode fault excluded", irq_err, 0);

    // R11 idle vs engine busy
    eng_busy = 1; #1;
    chk("R11 busy not idle", idle, 0);
    chk("R10 irq_idle off", irq_idle, 0);
    eng_busy = 0; #1;
    chk("R11 idle again", idle, 1);

    finish_run();
  end
endmodule